// File: doc/BRIEF.md
# Dual-Channel Feed Supply Controller

This block holds the control settings for two supply channels that power satellite feed electronics. For each channel it stores an enable, a high/low level select, a +1 V cable-drop compensation flag, a continuous-tone flag and a current-threshold flag. From these it derives a 2-bit target-voltage code, a converter enable and a current-threshold select for the analog side.

The block also produces a 22 kHz tone for each channel. A system-clock divider generates the tone at 50% duty. Each channel either sends the tone continuously, when its register flag is set, or gates it with an external keying pin. An external 18 V select pin for each channel is ORed with the register level bit. An over-temperature input wipes every stored bit, which shuts both channels down until the host writes them again.

The host uses a plain parallel port. A write strobe, a channel address and a data word write the bits. The read data always shows the stored bits of the addressed channel.

Top module: `feed_supply_ctrl`

## Requirements
- R1: After reset every stored bit is zero, so convEn, curHigh, voltCode, toneOut and rdData are all zero.
- R2: A write with wrEn high loads wrData into the channel named by addr on the next clock edge and leaves the other channel unchanged. rdData shows the stored bits of the addressed channel. The field positions are: bit 0 enable, bit 1 upper level, bit 2 compensation, bit 3 continuous tone, bit 4 high current threshold.
- R3: convEn[c] equals the enable bit of channel c, and each channel is enabled independently.
- R4: voltCode[2c+1:2c] encodes the target as 00=13 V, 01=14 V, 10=18 V, 11=19 V. The upper bit is the level bit ORed with sel18Pin[c], and the lower bit is the compensation bit.
- R5: While sel18Pin[c] is high, the code of channel c is 18 V or 19 V, even when the level bit is low.
- R6: While the continuous-tone bit of a channel is set, toneOut of that channel toggles with high and low phases of exactly TONE_HALF clocks each, whatever level toneKey has.
- R7: While the continuous-tone bit is clear, toneOut is low whenever toneKey is low, and carries the tone (TONE_HALF high clocks in every 2*TONE_HALF) while toneKey is high.
- R8: When overTemp is high at a clock edge, all bits of both channels are zero after that edge, even if a write arrives in the same cycle. They stay zero until they are written again.
- R9: curHigh[c] equals the high-threshold bit of channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| addr | input | ADDR_W | Channel to write and to read |
| wrData | input | 5 | Bits to store |
| rdData | output | 5 | Stored bits of the addressed channel |
| overTemp | input | 1 | Over-temperature event, clears all bits |
| toneKey | input | NUM_CH | External tone keying pin per channel |
| sel18Pin | input | NUM_CH | External upper-level select pin per channel |
| convEn | output | NUM_CH | Converter enable per channel |
| curHigh | output | NUM_CH | High current threshold select per channel |
| voltCode | output | 2*NUM_CH | Target voltage code, two bits per channel |
| toneOut | output | NUM_CH | Gated 22 kHz tone per channel |

## Verification
The assertions check five properties on every cycle. A thermal event clears everything on the following cycle. Each enable follows the write that targets it. A high select pin always forces the upper level. With both the keying pin and the continuous-tone flag low, the tone is silent. The tone phase never runs longer than TONE_HALF clocks. Only the bench scenarios show the rest: the full code table against every data and pin combination, that a write leaves the neighbouring channel alone, the exact duty and run lengths of the tone, and that cleared bits stay cleared after the thermal event ends.

// File: rtl/feed_supply_pkg.sv
package feed_supply_pkg;

  localparam int CH_BITS = 5;

  // Stored control word of one channel, enable in the LSB.
  typedef struct packed {
    logic iHigh;
    logic toneCont;
    logic lossComp;
    logic lvlHigh;
    logic en;
  } chanBits_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wipe;
    logic load;
    logic phaseFlip;
  } ctrlStrobe_t;

endpackage

// File: rtl/feed_supply_ctrl_unit.sv
module feed_supply_ctrl_unit
  import feed_supply_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int TONE_HALF = 1136,
  parameter int ADDR_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              overTemp,
  output ctrlStrobe_t       strobe
);

  localparam int CNT_W = (TONE_HALF > 1) ? $clog2(TONE_HALF) : 1;
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(TONE_HALF - 1);

  logic [CNT_W-1:0] divCnt;
  logic             addrOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
    end else if (divCnt == DIV_LAST) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign addrOk = ({1'b0, addr} < (ADDR_W + 1)'(NUM_CH));

  always_comb begin
    strobe.phaseFlip = (divCnt == DIV_LAST);
    strobe.wipe      = overTemp;
    strobe.load      = wrEn & ~overTemp & addrOk;
  end

endmodule

// File: rtl/feed_supply_datapath.sv
module feed_supply_datapath
  import feed_supply_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctrlStrobe_t               strobe,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CH_BITS-1:0]        wrData,
  input  logic [NUM_CH-1:0]         toneKey,
  input  logic [NUM_CH-1:0]         sel18Pin,
  output logic [CH_BITS-1:0]        rdData,
  output logic [NUM_CH-1:0]         convEn,
  output logic [NUM_CH-1:0]         curHigh,
  output logic [2*NUM_CH-1:0]       voltCode,
  output logic [NUM_CH-1:0]         toneOut,
  output logic                      phase,
  output logic [NUM_CH*CH_BITS-1:0] ctrlFlat
);

  chanBits_t chanRegs [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
    end else if (strobe.phaseFlip) begin
      phase <= ~phase;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chanRegs[c] <= '0;
      end else if (strobe.wipe) begin
        chanRegs[c] <= '0;
      end else if (strobe.load && (int'(addr) == c)) begin
        chanRegs[c] <= chanBits_t'(wrData);
      end
    end

    assign convEn[c]          = chanRegs[c].en;
    assign curHigh[c]         = chanRegs[c].iHigh;
    assign voltCode[2*c+1]    = chanRegs[c].lvlHigh | sel18Pin[c];
    assign voltCode[2*c]      = chanRegs[c].lossComp;
    assign toneOut[c]         = phase & (chanRegs[c].toneCont | toneKey[c]);
    assign ctrlFlat[c*CH_BITS +: CH_BITS] = chanRegs[c];
  end

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(addr) == c) rdData = chanRegs[c];
    end
  end

endmodule

// File: rtl/feed_supply_ctrl.sv
module feed_supply_ctrl
  import feed_supply_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int TONE_HALF = 1136,
  localparam int ADDR_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CH_BITS-1:0]  wrData,
  output logic [CH_BITS-1:0]  rdData,
  input  logic                overTemp,
  input  logic [NUM_CH-1:0]   toneKey,
  input  logic [NUM_CH-1:0]   sel18Pin,
  output logic [NUM_CH-1:0]   convEn,
  output logic [NUM_CH-1:0]   curHigh,
  output logic [2*NUM_CH-1:0] voltCode,
  output logic [NUM_CH-1:0]   toneOut
);

  ctrlStrobe_t                strobe;
  logic                       phase;
  logic [NUM_CH*CH_BITS-1:0]  ctrlFlat;

  feed_supply_ctrl_unit #(
    .NUM_CH(NUM_CH), .TONE_HALF(TONE_HALF), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr),
    .overTemp(overTemp), .strobe(strobe)
  );

  feed_supply_datapath #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .addr(addr),
    .wrData(wrData), .toneKey(toneKey), .sel18Pin(sel18Pin),
    .rdData(rdData), .convEn(convEn), .curHigh(curHigh),
    .voltCode(voltCode), .toneOut(toneOut), .phase(phase),
    .ctrlFlat(ctrlFlat)
  );

endmodule

// File: rtl/feed_supply_chk.sv
module feed_supply_chk
  import feed_supply_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int TONE_HALF = 1136,
  parameter int ADDR_W    = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wrEn,
  input logic [ADDR_W-1:0]         addr,
  input logic [CH_BITS-1:0]        wrData,
  input logic                      overTemp,
  input logic [NUM_CH-1:0]         toneKey,
  input logic [NUM_CH-1:0]         sel18Pin,
  input logic [NUM_CH-1:0]         convEn,
  input logic [NUM_CH-1:0]         curHigh,
  input logic [2*NUM_CH-1:0]       voltCode,
  input logic [NUM_CH-1:0]         toneOut,
  input logic                      phase,
  input logic [NUM_CH*CH_BITS-1:0] ctrlFlat
);

  localparam int RUN_W = $clog2(TONE_HALF + 1) + 1;

  logic             prevPhase;
  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevPhase <= 1'b0;
      runCnt    <= '0;
    end else begin
      prevPhase <= phase;
      if (phase != prevPhase) runCnt <= RUN_W'(1);
      else                    runCnt <= runCnt + 1'b1;
    end
  end

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    runCnt <= RUN_W'(TONE_HALF)); // R6

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    overTemp |=> (convEn == '0 && curHigh == '0 && ctrlFlat == '0)); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_ENABLE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && !overTemp && int'(addr) == c) |=> (convEn[c] == $past(wrData[0]))); // R3

    AST_PIN_FORCES_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      sel18Pin[c] |-> voltCode[2*c+1]); // R5

    AST_KEYLESS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!toneKey[c] && !ctrlFlat[c*CH_BITS+3]) |-> !toneOut[c]); // R7
  end

endmodule

bind feed_supply_ctrl feed_supply_chk #(
  .NUM_CH(NUM_CH), .TONE_HALF(TONE_HALF), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .overTemp(overTemp), .toneKey(toneKey), .sel18Pin(sel18Pin),
  .convEn(convEn), .curHigh(curHigh), .voltCode(voltCode),
  .toneOut(toneOut), .phase(phase), .ctrlFlat(ctrlFlat)
);

// File: tb/feed_supply_ctrl_test.sv
module feed_supply_ctrl_test;

  localparam int HALF = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [0:0] addr = '0;
  logic [4:0] wrData = '0;
  logic [4:0] rdData;
  logic       overTemp = 1'b0;
  logic [1:0] toneKey = '0;
  logic [1:0] sel18Pin = '0;
  logic [1:0] convEn, curHigh, toneOut;
  logic [3:0] voltCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  feed_supply_ctrl #(.NUM_CH(2), .TONE_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .overTemp(overTemp), .toneKey(toneKey),
    .sel18Pin(sel18Pin), .convEn(convEn), .curHigh(curHigh),
    .voltCode(voltCode), .toneOut(toneOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeCh(input int ch, input int val);
    @(negedge clk);
    wrEn = 1'b1; addr = 1'(ch); wrData = 5'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic countHighs(input int ch, input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (toneOut[ch]) highs++;
    end
  endtask

  initial begin
    int highs;
    int expCode;
    int other;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(convEn == 0 && curHigh == 0 && voltCode == 0 && toneOut == 0, "R1 outputs",
        int'({convEn, curHigh, voltCode, toneOut}), 0);
    chk(rdData == 0, "R1 rdData", int'(rdData), 0);

    // Sweep both channels over all data words and pin patterns: R2 R3 R4 R5 R9
    for (int ch = 0; ch < 2; ch++) begin
      other = (ch == 0) ? 5'b10110 : 5'b01001;
      writeCh(1 - ch, other);
      for (int v = 0; v < 32; v++) begin
        writeCh(ch, v);
        for (int p = 0; p < 4; p++) begin
          sel18Pin = 2'(p);
          addr = 1'(ch);
          #1;
          chk(rdData == 5'(v), "R2 readback", int'(rdData), v);
          chk(convEn[ch] == v[0], "R3 enable", int'(convEn[ch]), v[0]);
          chk(curHigh[ch] == v[4], "R9 threshold", int'(curHigh[ch]), v[4]);
          expCode = 2 * ((v >> 1) & 1 | (p >> ch) & 1) + ((v >> 2) & 1);
          chk(int'(voltCode[2*ch +: 2]) == expCode, "R4 code",
              int'(voltCode[2*ch +: 2]), expCode);
          if ((p >> ch) & 1)
            chk(voltCode[2*ch+1] == 1'b1, "R5 pin forces upper", int'(voltCode[2*ch+1]), 1);
          addr = 1'(1 - ch);
          #1;
          chk(rdData == 5'(other), "R2 neighbour untouched", int'(rdData), other);
          chk(convEn[1-ch] == other[0], "R3 independent", int'(convEn[1-ch]), other[0]);
        end
      end
    end
    sel18Pin = '0;

    // R7: keyed tone
    writeCh(0, 5'b00001);
    writeCh(1, 5'b00001);
    toneKey = 2'b00;
    countHighs(0, 4 * HALF, highs);
    chk(highs == 0, "R7 silent with key low", highs, 0);
    toneKey = 2'b01;
    countHighs(0, 2 * HALF, highs);
    chk(highs == HALF, "R7 tone with key high", highs, HALF);
    chk(toneOut[1] == 1'b0, "R7 other channel silent", int'(toneOut[1]), 0);
    toneKey = 2'b00;

    // R6: continuous tone regardless of key, exact run lengths
    writeCh(1, 5'b01000);
    for (int k = 0; k < 2; k++) begin
      toneKey = 2'(k << 1);
      countHighs(1, 2 * HALF, highs);
      chk(highs == HALF, "R6 duty", highs, HALF);
    end
    toneKey = 2'b00;
    begin
      int runLen;
      int seen;
      bit last;
      @(negedge clk);
      last = toneOut[1];
      runLen = 0;
      seen = 0;
      for (int i = 0; i < 8 * HALF; i++) begin
        @(negedge clk);
        runLen++;
        if (toneOut[1] != last) begin
          if (seen > 0) chk(runLen == HALF, "R6 run length", runLen, HALF);
          seen++;
          runLen = 0;
          last = toneOut[1];
        end
      end
      chk(seen >= 6, "R6 toggles seen", seen, 6);
    end

    // R8: thermal wipe wins over simultaneous write, and persists
    writeCh(0, 5'b11111);
    writeCh(1, 5'b10101);
    @(negedge clk);
    overTemp = 1'b1; wrEn = 1'b1; addr = 1'b0; wrData = 5'b00111;
    @(negedge clk);
    overTemp = 1'b0; wrEn = 1'b0;
    addr = 1'b0; #1;
    chk(rdData == 0, "R8 channel 0 cleared", int'(rdData), 0);
    addr = 1'b1; #1;
    chk(rdData == 0, "R8 channel 1 cleared", int'(rdData), 0);
    repeat (3 * HALF) @(negedge clk);
    chk(convEn == 0 && curHigh == 0 && voltCode == 0, "R8 stays cleared",
        int'({convEn, curHigh, voltCode}), 0);
    countHighs(0, 2 * HALF, highs);
    chk(highs == 0, "R8 tone off after wipe", highs, 0);
    writeCh(0, 5'b00001);
    chk(convEn == 2'b01, "R8 re-enable", int'(convEn), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule